// File: doc/BRIEF.md
# Tearing-Effect Sync Line Detector

A display module with its own frame memory reports its refresh position on one or two sync wires. This block watches those wires and works out when a vertical sync (start of frame) or a horizontal sync (next line) has occurred. It counts lines from the last vertical sync. When software has asked for a transfer, it raises a single-cycle trigger once the count reaches a programmed line. The pixel transfer that follows is outside this block.

Three operating settings exist. With synchronisation off, a start request fires the trigger on the next cycle and nothing waits on the wires. In the combined-wire setting a single wire carries both kinds of sync, and the block tells them apart only by how long each active pulse lasts compared with two programmed widths. In the split-wire setting, one wire carries vertical sync and the other carries horizontal sync. Each wire is inverted where its polarity bit asks for it, then passed through two flops, then measured by a small per-wire state machine (states `M_IDLE`, `M_ACTIVE`; transition `M_IDLE→M_ACTIVE` when the wire becomes active, `M_ACTIVE→M_IDLE` when it becomes inactive, which reports the measured width). A tracker state machine holds the request (states `T_IDLE`, `T_WAIT`, `T_FIRE`). Its transitions are: `T_IDLE→T_FIRE` on a request with sync off; `T_IDLE→T_WAIT` on a request with sync on; `T_WAIT→T_FIRE` on a line match, or when sync is switched off; `T_FIRE→T_IDLE` always.

Top module: `te_sync_detect`

## Requirements
- R1: `cfg_mode` encodes 0 = sync off, 1 = combined wire on `te_pin0`, 2 = split wires (`te_pin0` vertical, `te_pin1` horizontal); 3 behaves exactly as 0.
- R2: A pulse's width is the number of rising edges that sample it active after the two-flop synchroniser. Its event (`vs_evt` or `hs_evt`) is high for one cycle, registered at the second rising edge after the first edge at which the raw pin is inactive.
- R3: In mode 1 a pulse of width ≥ `cfg_vs_width` gives `vs_evt`. A pulse with `cfg_hs_width` ≤ width < `cfg_vs_width` gives `hs_evt`. Shorter pulses give no event.
- R4: In mode 2 a `te_pin0` pulse of width ≥ `cfg_vs_width` gives `vs_evt`, and a `te_pin1` pulse of width ≥ `cfg_hs_width` gives `hs_evt`. In mode 1 `te_pin1` has no effect, and in modes 0 and 3 neither pin produces events.
- R5: `cfg_vs_inv` sets the active level of `te_pin0` and `cfg_hs_inv` that of `te_pin1`: 0 = active high (the reset value a system should program), 1 = active low.
- R6: `line_cnt` (11 bits) becomes 0 the cycle after `vs_evt` and increments by one the cycle after `hs_evt`, wrapping from 2047 to 0. When both events occur together, vertical wins. Without events it holds.
- R7: With sync off, a `start_req` sampled in `T_IDLE` makes `xfer_trig` high for exactly the next cycle, after which it clears by itself.
- R8: With sync on, a `start_req` arms the block. `xfer_trig` is high in the cycle after an edge that sees the block armed with `line_cnt == cfg_line`.
- R9: A `start_req` while armed or while `xfer_trig` is high is ignored and causes no second trigger.
- R10: Switching to sync off while armed fires `xfer_trig` in the next cycle.
- R11: After reset `line_cnt` = 0 and `xfer_trig`, `vs_evt` and `hs_evt` are low.
- R12: `xfer_trig` is never high in two consecutive cycles, and in mode 1 `vs_evt` and `hs_evt` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Sync setting (R1) |
| cfg_hs_width | input | 8 | Minimum horizontal pulse width in cycles |
| cfg_vs_width | input | 8 | Minimum vertical pulse width in cycles |
| cfg_hs_inv | input | 1 | Horizontal wire active low when 1 |
| cfg_vs_inv | input | 1 | Vertical / combined wire active low when 1 |
| cfg_line | input | 11 | Line number that releases an armed request |
| start_req | input | 1 | Transfer request, one cycle |
| te_pin0 | input | 1 | Vertical or combined sync wire, asynchronous |
| te_pin1 | input | 1 | Horizontal sync wire, asynchronous |
| vs_evt | output | 1 | Vertical sync recognised |
| hs_evt | output | 1 | Horizontal sync recognised |
| line_cnt | output | 11 | Lines since last vertical sync |
| xfer_trig | output | 1 | One-cycle transfer trigger |

## Verification
The assertions take the width configuration as legal whenever sync is on. The horizontal width must be at least 2. The vertical width must be at least 4 and larger than the horizontal width in mode 1, and at least 2 and different from the horizontal width in mode 2. They also take the configuration as steady while a pulse is being measured. The stimulus holds the widths at 3 and 6, which satisfies both modes. It changes mode and polarity only while both wires sit at their idle level, and it changes polarity together with the idle level of the pins, so a polarity change never creates a false pulse.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;

    // Sync setting carried on cfg_mode
    typedef enum logic [1:0] {
        TE_OFF     = 2'd0,
        TE_ONE_PIN = 2'd1,
        TE_TWO_PIN = 2'd2,
        TE_OFF_ALT = 2'd3
    } te_mode_e;

    // Per-wire pulse measurement states
    typedef enum logic {
        M_IDLE   = 1'b0,
        M_ACTIVE = 1'b1
    } meas_state_e;

    // Request tracker states
    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_WAIT = 2'd1,
        T_FIRE = 2'd2
    } trk_state_e;

    function automatic logic sync_enabled(input te_mode_e m);
        return (m == TE_ONE_PIN) || (m == TE_TWO_PIN);
    endfunction

endpackage

// File: rtl/te_pin_sync.sv
module te_pin_sync #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] raw_in,
    input  logic [NPIN-1:0] inv,
    output logic [NPIN-1:0] act_out
);

    // Polarity applied before the flops so reset means "inactive"
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic stage1;
        logic stage2;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= raw_in[p] ^ inv[p];
                stage2 <= stage1;
            end
        end

        assign act_out[p] = stage2;
    end

endmodule

// File: rtl/te_pulse_meas.sv
module te_pulse_meas
    import te_sync_pkg::*;
#(
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    output logic          end_strb,
    output logic [WW-1:0] width
);

    meas_state_e   state_q;
    meas_state_e   state_d;
    logic [WW-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE:   if (act)  state_d = M_ACTIVE;
            M_ACTIVE: if (!act) state_d = M_IDLE;
            default:            state_d = M_IDLE;
        endcase
    end

    // Outputs and width counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            end_strb <= 1'b0;
            width    <= '0;
        end else begin
            end_strb <= 1'b0;
            unique case (state_q)
                M_IDLE: begin
                    if (act) cnt_q <= {{(WW-1){1'b0}}, 1'b1};
                end
                M_ACTIVE: begin
                    if (act) begin
                        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                    end else begin
                        end_strb <= 1'b1;
                        width    <= cnt_q;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // R2
    end_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_strb |-> (width != '0));

    // R2
    end_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_strb |-> $past(!act));

endmodule

// File: rtl/te_line_tracker.sv
module te_line_tracker
    import te_sync_pkg::*;
#(
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_on,
    input  logic          vs_evt,
    input  logic          hs_evt,
    input  logic [LW-1:0] cfg_line,
    input  logic          start_req,
    output logic [LW-1:0] line_cnt,
    output logic          xfer_trig
);

    trk_state_e state_q;
    trk_state_e state_d;
    logic       line_hit;

    assign line_hit = (line_cnt == cfg_line);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE: begin
                if (start_req) state_d = sync_on ? T_WAIT : T_FIRE;
            end
            T_WAIT: begin
                if (!sync_on || line_hit) state_d = T_FIRE;
            end
            T_FIRE:  state_d = T_IDLE;
            default: state_d = T_IDLE;
        endcase
    end

    // Outputs
    assign xfer_trig = (state_q == T_FIRE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      line_cnt <= '0;
        else if (vs_evt) line_cnt <= '0;
        else if (hs_evt) line_cnt <= line_cnt + 1'b1;
    end

    // R12
    trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_trig |=> !xfer_trig);

    // R6
    line_vs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_evt |=> (line_cnt == '0));

    // R6
    line_hs_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_evt && !vs_evt) |=> (line_cnt == LW'($past(line_cnt) + 1'b1)));

    // R6
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_evt && !vs_evt) |=> $stable(line_cnt));

    // R7
    nosync_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_IDLE && start_req && !sync_on) |=> xfer_trig);

    // R10
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_WAIT && !sync_on) |=> xfer_trig);

endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect
    import te_sync_pkg::*;
#(
    parameter int WW = 8,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic [WW-1:0] cfg_hs_width,
    input  logic [WW-1:0] cfg_vs_width,
    input  logic          cfg_hs_inv,
    input  logic          cfg_vs_inv,
    input  logic [LW-1:0] cfg_line,
    input  logic          start_req,
    input  logic          te_pin0,
    input  logic          te_pin1,
    output logic          vs_evt,
    output logic          hs_evt,
    output logic [LW-1:0] line_cnt,
    output logic          xfer_trig
);

    localparam int NPIN = 2;

    te_mode_e          mode;
    logic              sync_on;
    logic [NPIN-1:0]   pin_act;
    logic [NPIN-1:0]   pin_end;
    logic [WW-1:0]     pin_width [NPIN];

    assign mode    = te_mode_e'(cfg_mode);
    assign sync_on = sync_enabled(mode);

    te_pin_sync #(.NPIN(NPIN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_in  ({te_pin1, te_pin0}),
        .inv     ({cfg_hs_inv, cfg_vs_inv}),
        .act_out (pin_act)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_meas
        te_pulse_meas #(.WW(WW)) u_meas (
            .clk      (clk),
            .rst_n    (rst_n),
            .act      (pin_act[p]),
            .end_strb (pin_end[p]),
            .width    (pin_width[p])
        );
    end

    // Pulse classification by mode
    always_comb begin
        vs_evt = 1'b0;
        hs_evt = 1'b0;
        unique case (mode)
            TE_ONE_PIN: begin
                if (pin_end[0]) begin
                    if (pin_width[0] >= cfg_vs_width)      vs_evt = 1'b1;
                    else if (pin_width[0] >= cfg_hs_width) hs_evt = 1'b1;
                end
            end
            TE_TWO_PIN: begin
                vs_evt = pin_end[0] && (pin_width[0] >= cfg_vs_width);
                hs_evt = pin_end[1] && (pin_width[1] >= cfg_hs_width);
            end
            TE_OFF, TE_OFF_ALT: begin
                vs_evt = 1'b0;
                hs_evt = 1'b0;
            end
            default: begin
                vs_evt = 1'b0;
                hs_evt = 1'b0;
            end
        endcase
    end

    te_line_tracker #(.LW(LW)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_on   (sync_on),
        .vs_evt    (vs_evt),
        .hs_evt    (hs_evt),
        .cfg_line  (cfg_line),
        .start_req (start_req),
        .line_cnt  (line_cnt),
        .xfer_trig (xfer_trig)
    );

    // R12
    onepin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TE_ONE_PIN) |-> !(vs_evt && hs_evt));

    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_on |-> !(vs_evt || hs_evt));

    // R3
    onepin_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TE_ONE_PIN) |-> (cfg_hs_width >= WW'(2) && cfg_vs_width >= WW'(4)
                                  && cfg_vs_width > cfg_hs_width));

    // R4
    twopin_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TE_TWO_PIN) |-> (cfg_hs_width >= WW'(2) && cfg_vs_width >= WW'(2)
                                  && cfg_vs_width != cfg_hs_width));

endmodule

// File: tb/te_sync_detect_tb.sv
module te_sync_detect_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [7:0]  cfg_hs_width = 8'd3;
    logic [7:0]  cfg_vs_width = 8'd6;
    logic        cfg_hs_inv = 1'b0;
    logic        cfg_vs_inv = 1'b0;
    logic [10:0] cfg_line = 11'd0;
    logic        start_req = 1'b0;
    logic        te_pin0 = 1'b0;
    logic        te_pin1 = 1'b0;
    logic        vs_evt, hs_evt, xfer_trig;
    logic [10:0] line_cnt;

    int n_checks = 0;
    int n_fail = 0;
    int trig_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    te_sync_detect u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cfg_hs_width(cfg_hs_width), .cfg_vs_width(cfg_vs_width),
        .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv),
        .cfg_line(cfg_line), .start_req(start_req),
        .te_pin0(te_pin0), .te_pin1(te_pin1),
        .vs_evt(vs_evt), .hs_evt(hs_evt),
        .line_cnt(line_cnt), .xfer_trig(xfer_trig)
    );

    // ---------------- behavioural reference ----------------
    bit hist0[$];
    bit hist1[$];
    bit m_act[2];
    int m_cnt[2];
    bit m_end[2];
    int m_w[2];
    int m_line;
    bit m_pend;
    bit m_trig;

    function automatic bit m_sync_on();
        return (cfg_mode == 2'd1) || (cfg_mode == 2'd2);
    endfunction

    function automatic bit m_vs();
        if (cfg_mode == 2'd1) return m_end[0] && (m_w[0] >= int'(cfg_vs_width));
        if (cfg_mode == 2'd2) return m_end[0] && (m_w[0] >= int'(cfg_vs_width));
        return 1'b0;
    endfunction

    function automatic bit m_hs();
        if (cfg_mode == 2'd1)
            return m_end[0] && (m_w[0] < int'(cfg_vs_width)) && (m_w[0] >= int'(cfg_hs_width));
        if (cfg_mode == 2'd2) return m_end[1] && (m_w[1] >= int'(cfg_hs_width));
        return 1'b0;
    endfunction

    task automatic cmp(input string req, input string sig, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, sig, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            hist0.delete(); hist1.delete();
            for (int p = 0; p < 2; p++) begin
                m_act[p] = 0; m_cnt[p] = 0; m_end[p] = 0; m_w[p] = 0;
            end
            m_line = 0; m_pend = 0; m_trig = 0;
        end else begin
            bit ev_v, ev_h, nxt_trig;
            bit s2[2];
            ev_v = m_vs();
            ev_h = m_hs();
            // compare current outputs (pre-update values) - R3/R4/R6/R7/R8
            cmp(cfg_mode == 2'd2 ? "R4" : "R3", "vs_evt", int'(vs_evt), int'(ev_v));
            cmp(cfg_mode == 2'd2 ? "R4" : "R3", "hs_evt", int'(hs_evt), int'(ev_h));
            cmp("R6", "line_cnt", int'(line_cnt), m_line);
            cmp(m_sync_on() ? "R8" : "R7", "xfer_trig", int'(xfer_trig), int'(m_trig));
            if (xfer_trig) trig_seen++;
            // tracker
            nxt_trig = 0;
            if (m_trig) begin
            end else if (m_pend) begin
                if (!m_sync_on() || m_line == int'(cfg_line)) begin
                    nxt_trig = 1; m_pend = 0;
                end
            end else if (start_req) begin
                if (m_sync_on()) m_pend = 1;
                else nxt_trig = 1;
            end
            m_trig = nxt_trig;
            if (ev_v) m_line = 0;
            else if (ev_h) m_line = (m_line + 1) % 2048;
            // width measurement after two-stage delay
            s2[0] = (hist0.size() >= 2) ? hist0[hist0.size()-2] : 1'b0;
            s2[1] = (hist1.size() >= 2) ? hist1[hist1.size()-2] : 1'b0;
            for (int p = 0; p < 2; p++) begin
                m_end[p] = 0;
                if (s2[p]) begin
                    if (!m_act[p]) begin m_act[p] = 1; m_cnt[p] = 1; end
                    else if (m_cnt[p] < 255) m_cnt[p]++;
                end else if (m_act[p]) begin
                    m_end[p] = 1; m_w[p] = m_cnt[p]; m_act[p] = 0;
                end
            end
            hist0.push_back(te_pin0 ^ cfg_vs_inv);
            hist1.push_back(te_pin1 ^ cfg_hs_inv);
            if (hist0.size() > 4) void'(hist0.pop_front());
            if (hist1.size() > 4) void'(hist1.pop_front());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input int pin, input bit active);
        if (pin == 0) te_pin0 = active ? !cfg_vs_inv : cfg_vs_inv;
        else          te_pin1 = active ? !cfg_hs_inv : cfg_hs_inv;
    endtask

    task automatic pulse(input int pin, input int len, input int gap);
        @(negedge clk); set_pin(pin, 1);
        idle(len);      set_pin(pin, 0);
        idle(gap);
    endtask

    task automatic pulse_both(input int len, input int gap);
        @(negedge clk); set_pin(0, 1); set_pin(1, 1);
        idle(len);      set_pin(0, 0); set_pin(1, 0);
        idle(gap);
    endtask

    task automatic request();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int t0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        cmp("R11", "line_cnt", int'(line_cnt), 0);
        cmp("R11", "xfer_trig", int'(xfer_trig), 0);
        cmp("R11", "vs_evt|hs_evt", int'(vs_evt | hs_evt), 0);

        // R7 no sync: immediate self-clearing trigger
        t0 = trig_seen;
        request(); idle(4);
        cmp("R7", "trig_count", trig_seen - t0, 1);

        // R1 mode 3 behaves as off; pulses produce nothing
        cfg_mode = 2'd3;
        pulse(0, 8, 4);
        cmp("R1", "line_cnt", int'(line_cnt), 0);
        t0 = trig_seen;
        request(); idle(4);
        cmp("R1", "trig_count", trig_seen - t0, 1);

        // R3 combined wire classification
        cfg_mode = 2'd1;
        idle(2);
        pulse(0, 8, 4);   // vertical
        pulse(0, 3, 4);   // horizontal
        pulse(0, 5, 4);   // horizontal (just under vertical)
        pulse(0, 2, 4);   // too short
        pulse(0, 3, 4);   // horizontal
        cmp("R3", "line_cnt", int'(line_cnt), 3);
        pulse(0, 6, 4);   // exactly vertical width
        cmp("R3", "line_cnt", int'(line_cnt), 0);
        // R4 second wire ignored in mode 1
        pulse(1, 4, 4);
        cmp("R4", "line_cnt", int'(line_cnt), 0);

        // R8 / R9 armed trigger at line 2
        cfg_line = 11'd2;
        t0 = trig_seen;
        request(); idle(2);
        request();          // ignored while armed (R9)
        pulse(0, 3, 4);
        cmp("R8", "trig_count_line1", trig_seen - t0, 0);
        pulse(0, 3, 6);
        cmp("R8", "trig_count_line2", trig_seen - t0, 1);
        pulse(0, 3, 6);
        cmp("R9", "trig_count", trig_seen - t0, 1);

        // R5 / R4 split wires with inverted polarity
        cfg_mode = 2'd2;
        cfg_vs_inv = 1'b1; cfg_hs_inv = 1'b1;
        te_pin0 = 1'b1; te_pin1 = 1'b1;
        idle(4);
        pulse(0, 7, 4);
        pulse(1, 3, 4);
        pulse(1, 2, 4);   // too short
        pulse(1, 4, 4);
        pulse(0, 3, 4);   // too short for vertical
        cmp("R5", "line_cnt", int'(line_cnt), 2);
        // R6 simultaneous: vertical wins
        pulse_both(7, 4);
        cmp("R6", "line_cnt_both", int'(line_cnt), 0);

        // R10 arm on unreachable line, then switch off
        cfg_line = 11'd1000;
        t0 = trig_seen;
        request(); idle(3);
        cmp("R10", "trig_count_armed", trig_seen - t0, 0);
        @(negedge clk); cfg_mode = 2'd0;
        idle(3);
        cmp("R10", "trig_count", trig_seen - t0, 1);

        // R6 wrap: 2048 horizontal pulses in combined mode, active high
        cfg_vs_inv = 1'b0; cfg_hs_inv = 1'b0;
        te_pin0 = 1'b0; te_pin1 = 1'b0;
        idle(4);
        cfg_mode = 2'd1;
        pulse(0, 7, 4);
        for (int i = 0; i < 2048; i++) pulse(0, 3, 2);
        idle(3);
        cmp("R6", "line_cnt_wrap", int'(line_cnt), 0);
        pulse(0, 3, 4);
        cmp("R6", "line_cnt_after_wrap", int'(line_cnt), 1);

        idle(5);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule